// File: doc/BRIEF.md
# External Data-Memory Bus Sequencer

This block runs single reads and writes to external data memory over a multiplexed bus. The low address byte and the data share one 8-bit port. The high address byte sits on a separate port. A request carries a 16-bit address, a direction bit, write data and a 3-bit stretch value. The sequencer puts the low address on the shared port with the address-latch strobe high. After the strobe falls it turns the shared port into a data bus: driven for a write, released for a read. It then pulses the read or write strobe, both active low.

The length of an access is counted in machine cycles of four clocks each. An access lasts n+2 machine cycles, where n is the stretch value sampled when the request is accepted. This lets slow memories or peripherals share the bus with fast ones. Read data is captured just before the read strobe is released. A one-clock done pulse follows the capture, and the read data stays valid until the next read. The program-fetch enable is not sequenced here and is held high.

Top module: `xbus_seq`

## Requirements
- R1: While reset is asserted, and whenever no access is in progress, the block is idle. In that state ad_oe=0, ale=0, rd_n=1, wr_n=1, busy=0, done=0 and a_hi=8'hFF.
- R2: The block accepts a request on a clock edge where req_valid=1 and busy=0. Access clock 0 is the cycle after that edge, and busy is 1 from clock 0 through the last access clock. A request presented while busy=1 is ignored: the running access keeps its address, data, direction and length.
- R3: On access clocks 0 and 1, ale=1, ad_oe=1 and ad_out equals the low address byte. On clock 2, ale=0 and the low address byte is still driven with ad_oe=1.
- R4: a_hi equals address bits 15:8 on every access clock.
- R5: An access lasts T=(n+2)*4 clocks, with n taken from req_stretch when the request is accepted. done is 1 on access clock T-1 only, so it lasts exactly one clock. The next idle cycle follows directly.
- R6: For a write (req_write=1), ad_oe=1 and ad_out equals the write data from clock 3 through clock T-1. wr_n=0 on clocks 4 through T-2 only, so data is driven one clock before the strobe falls and one clock after it rises.
- R7: For a read (req_write=0), ad_oe=0 from clock 3 through clock T-1, and rd_n=0 on clocks 4 through T-2 only. rdata takes the value of ad_in sampled on the clock edge that ends clock T-2. It is valid from clock T-1 and keeps that value through later writes until the next read captures.
- R8: rd_n and wr_n are never low together, and psen_n is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_stretch | input | 3 | Stretch n, access length n+2 machine cycles |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock pulse on the last access clock |
| rdata | output | 8 | Captured read data |
| ale | output | 1 | Address latch strobe |
| ad_out | output | 8 | Shared address/data port, output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port, input value |
| a_hi | output | 8 | High address byte port |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| psen_n | output | 1 | Program-fetch enable, held high |

## Verification
All results are counted in clocks from the accepting edge. Clock k of an access is the k-th cycle after that edge. The bench computes the expected bus state for every k from 0 to T-1, with T=(n+2)*4. On each falling edge it compares ale, ad_oe, ad_out, a_hi, both strobes, busy and done with that state. Read data must be present at clock T-1, where done is checked, and must still hold in the idle cycle that follows. An idle cycle is checked after every access, and a pipeline slip of one clock shows up as a strobe or done mismatch at the edge of its window.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } xdir_e;

  // Access length in clocks for stretch value n and cpm clocks per machine cycle.
  function automatic int acc_clocks(int n, int cpm);
    return (n + 2) * cpm;
  endfunction

  // Width needed to count up to the longest access.
  function automatic int cnt_width(int stretch_w, int cpm);
    return $clog2(acc_clocks((1 << stretch_w) - 1, cpm));
  endfunction

endpackage

// File: rtl/xbus_seq_ctrl.sv
module xbus_seq_ctrl #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int SW  = 3,
  parameter int CPM = 4,
  parameter int CW  = xbus_pkg::cnt_width(SW, CPM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [SW-1:0] req_stretch,
  output logic          busy,
  output logic          last,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] len_m1,
  output xbus_pkg::xdir_e dir_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);
  import xbus_pkg::*;

  logic accept;
  assign accept = req_valid && !busy;
  assign last   = busy && (cnt == len_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      len_m1  <= '0;
      dir_q   <= DIR_RD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      cnt     <= '0;
      len_m1  <= CW'(acc_clocks(int'(req_stretch), CPM) - 1);
      dir_q   <= req_write ? DIR_WR : DIR_RD;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R5: the counter never runs past the length latched at acceptance
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= len_m1));

  // R2: a running access is not disturbed by new requests
  p_ignore_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && $stable(addr_q) && $stable(wdata_q)
                         && $stable(dir_q) && $stable(len_m1)));

  // R5: the access ends right after its last clock
  p_end_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);

endmodule

// File: rtl/xbus_phase_dec.sv
module xbus_phase_dec #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int CPM = 4,
  parameter int CW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic [CW-1:0]   cnt,
  input  logic [CW-1:0]   len_m1,
  input  xbus_pkg::xdir_e dir_q,
  input  logic [AW-1:0]   addr_q,
  input  logic [DW-1:0]   wdata_q,
  output logic            ale,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  output logic [AW-DW-1:0] a_hi,
  output logic            rd_n,
  output logic            wr_n,
  output logic            cap_en
);
  import xbus_pkg::*;

  // Phase boundaries, in clocks from the start of the access.
  localparam logic [CW-1:0] ALE_END  = CW'(CPM / 2);   // first clock with ALE low
  localparam logic [CW-1:0] STB_BEG  = CW'(CPM / 2 + 2); // first strobe clock

  logic in_addr, in_data, strobe_win, is_wr;

  assign in_addr    = busy && (cnt <= ALE_END);
  assign in_data    = busy && (cnt >  ALE_END);
  assign strobe_win = busy && (cnt >= STB_BEG) && (cnt < len_m1);
  assign is_wr      = (dir_q == DIR_WR);

  assign ale    = busy && (cnt < ALE_END);
  assign ad_oe  = in_addr || (in_data && is_wr);
  assign ad_out = in_addr ? addr_q[DW-1:0] : ((in_data && is_wr) ? wdata_q : '0);
  assign a_hi   = busy ? addr_q[AW-1:DW] : '1;
  assign wr_n   = !(strobe_win && is_wr);
  assign rd_n   = !(strobe_win && !is_wr);
  assign cap_en = strobe_win && !is_wr && (cnt == len_m1 - CW'(1));

  // R6: write strobe falls only after data has been driven for a clock
  p_wr_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> (ad_oe && $past(ad_oe) && !ale));

  // R6: data stays driven for the clock after the write strobe rises
  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe);

  // R7: nothing drives the shared port while the read strobe is low
  p_rd_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R3: the latch strobe is only high while an address is driven
  p_ale_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && rd_n && wr_n));

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int SW  = 3,
  parameter int CPM = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [SW-1:0] req_stretch,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          ale,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [AW-DW-1:0] a_hi,
  output logic          rd_n,
  output logic          wr_n,
  output logic          psen_n
);
  import xbus_pkg::*;

  localparam int CW = cnt_width(SW, CPM);

  logic            last, cap_en;
  logic [CW-1:0]   cnt, len_m1;
  xdir_e           dir_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;

  xbus_seq_ctrl #(.AW(AW), .DW(DW), .SW(SW), .CPM(CPM), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_stretch(req_stretch),
    .busy(busy), .last(last), .cnt(cnt), .len_m1(len_m1),
    .dir_q(dir_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  xbus_phase_dec #(.AW(AW), .DW(DW), .CPM(CPM), .CW(CW)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .busy(busy), .cnt(cnt), .len_m1(len_m1), .dir_q(dir_q),
    .addr_q(addr_q), .wdata_q(wdata_q),
    .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
    .rd_n(rd_n), .wr_n(wr_n), .cap_en(cap_en)
  );

  // Read data capture on the clock before the read strobe rises.
  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= ad_in;
  end

  assign done   = last;
  assign psen_n = 1'b1;

  // R8: strobes are mutually exclusive, program fetch enable idle
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n) && psen_n);

  // R5: done is a single-clock pulse
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: read data changes only after a capture, and capture precedes done
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(rdata));
  p_cap_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (done && rd_n));

endmodule

// File: tb/xbus_seq_bench.sv
module xbus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [2:0]  req_stretch = '0;
  logic        busy, done, ale, ad_oe, rd_n, wr_n, psen_n;
  logic [7:0]  rdata, ad_out, ad_in, a_hi;

  int nvec = 0, nbad = 0;
  bit finished = 0;
  logic [15:0] lat_addr = '0, wr_addr_seen = '0;
  logic [7:0]  wr_data_seen = '0, last_rd = '0;

  always #4 clk = ~clk;

  xbus_seq u_xbus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_stretch(req_stretch),
    .busy(busy), .done(done), .rdata(rdata), .ale(ale), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi), .rd_n(rd_n), .wr_n(wr_n),
    .psen_n(psen_n)
  );

  // Memory model: external latch plus a computed memory content.
  function automatic logic [7:0] mem_f(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  always @(negedge ale) lat_addr = {a_hi, ad_out};
  always @(posedge wr_n) begin
    wr_data_seen = ad_out;
    wr_addr_seen = lat_addr;
  end
  assign ad_in = !rd_n ? mem_f(lat_addr) : 8'h00;

  task automatic chk(bit ok, string req, int act, int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(string tag);
    chk(!ad_oe && !ale && rd_n && wr_n && !busy && !done && a_hi == 8'hFF,
        {"R1 ", tag}, {ad_oe, ale, rd_n, wr_n, busy, done, a_hi},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF});
    chk(psen_n == 1'b1, "R8 psen", psen_n, 1);
  endtask

  task automatic run_acc(bit wr, logic [15:0] a, logic [7:0] d, int n, bit poke);
    int t;
    t = (n + 2) * 4;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    req_stretch = 3'(n);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = ~wr;
    for (int k = 0; k < t; k++) begin
      bit e_ale, e_oe, e_str;
      logic [7:0] e_ad;
      if (k > 0) @(negedge clk);
      if (poke && k == 1) begin
        req_valid = 1'b1; req_stretch = 3'(7 - n);   // R2: must be ignored
      end
      if (poke && k == 2) req_valid = 1'b0;
      e_ale = (k < 2);
      e_oe  = (k < 3) || wr;
      e_ad  = (k < 3) ? a[7:0] : d;
      e_str = (k >= 4) && (k <= t - 2);
      chk(ale == e_ale, "R3 ale", ale, e_ale);
      chk(ad_oe == e_oe, wr ? "R6 oe" : "R7 oe", ad_oe, e_oe);
      if (e_oe) chk(ad_out == e_ad, (k < 3) ? "R3 addr" : "R6 data", ad_out, e_ad);
      chk(a_hi == a[15:8], "R4 a_hi", a_hi, a[15:8]);
      chk(wr_n == !(e_str && wr), "R6 wr_n", wr_n, !(e_str && wr));
      chk(rd_n == !(e_str && !wr), "R7 rd_n", rd_n, !(e_str && !wr));
      chk(!(~rd_n & ~wr_n), "R8 excl", {rd_n, wr_n}, 3);
      chk(busy == 1'b1, "R2 busy", busy, 1);
      chk(done == (k == t - 1), "R5 done", done, (k == t - 1));
      if (k == t - 1) begin
        if (!wr) begin
          last_rd = mem_f(a);
          chk(rdata == last_rd, "R7 rdata", rdata, last_rd);
        end else begin
          chk(wr_data_seen == d, "R6 wdata at strobe", wr_data_seen, d);
          chk(wr_addr_seen == a, "R6 waddr latched", wr_addr_seen, a);
        end
      end
    end
    @(negedge clk);
    chk_idle("after access R5");
    chk(rdata == last_rd, "R7 rdata hold", rdata, last_rd);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk_idle("in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); chk_idle("after reset");
    // Directed corners: shortest and longest, both directions, ignored request.
    run_acc(1'b1, 16'h12C3, 8'h5E, 0, 1'b0);
    run_acc(1'b0, 16'h12C3, 8'h00, 0, 1'b0);
    run_acc(1'b0, 16'hFE01, 8'h00, 7, 1'b1);
    run_acc(1'b1, 16'h0080, 8'hFF, 7, 1'b1);
    run_acc(1'b1, 16'hFFFF, 8'h00, 3, 1'b0);
    for (int i = 0; i < 40; i++) begin
      run_acc(1'($urandom), 16'($urandom), 8'($urandom), int'($urandom % 8),
              1'($urandom));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule